// File: doc/BRIEF.md
# Power-Management and SMBus I/O Window Decoder

This block keeps the configuration registers that place two relocatable I/O windows for a power-management function. The first is a 64-byte window for the power-management registers and the second is a 16-byte window for an SMBus host controller. Software programs a base address and an enable for each window. It does this with dword-addressed configuration writes that carry per-byte enables. The block applies per-register masking and forced bits as it stores each write.

Every incoming I/O address is compared against both windows. The block raises a hit flag for the window that claims the address and outputs the address bits that fall inside that window as an offset. The window registers sit behind these outputs and are not part of this block. Configuration reads are combinational over the stored state, so a read one cycle after a write returns the final masked value.

Top module: `pmsmb_window_decoder`

## Requirements
- R1: After reset, these reads return the following values: dword 0x40 reads 0x00000000, dword 0x48 reads 0x00000001, dword 0x80 reads 0x00000000, dword 0x90 reads 0x00000001 and dword 0xD0 reads 0x00000000. Both hit flags are low after reset.
- R2: A write to dword 0x40 or dword 0x48 replaces only the byte lanes whose `cfgByteEn` bit is set. Lane i holds bits 8i+7 to 8i. The new value is visible to a read in the next cycle.
- R3: The power-management window covers the 64 addresses whose bits 15:6 equal bits 15:6 of dword 0x40. On a hit, `ioOffset` is `ioAddr[5:0]`.
- R4: The power-management window decodes only while bit 0 of dword 0x80 is 1. Dword 0x80 stores byte lane 0 only, and its other bits read 0.
- R5: A write to dword 0x90 with any byte enable set merges the enabled lanes. The block then stores `(merged & 0xFFF0) | 1`. As a result, bit 0 always reads 1 and bits 31:16 always read 0.
- R6: The SMBus control byte is lane 2 of dword 0xD0. Only its low 4 bits are kept, and they read back in bits 19:16. All other bits of dword 0xD0 read 0. A write to dword 0xD0 without lane 2 enabled changes nothing.
- R7: The SMBus window covers the 16 addresses whose bits 15:4 equal bits 15:4 of dword 0x90, and it decodes only while bit 16 of dword 0xD0 is 1. On a hit, `ioOffset` is `ioAddr[3:0]` zero-extended.
- R8: When both windows claim an address, `pmHit` is 1, `smbHit` is 0 and the offset is taken from the power-management window. The two hit flags are never high together.
- R9: Reads of any other dword return 0, and writes to any other dword have no effect. A write with all byte enables clear has no effect. The low two bits of `cfgAddr` are ignored. When neither window hits, `ioOffset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address (low two bits ignored) |
| cfgByteEn | input | 4 | Byte-lane enables for the write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data for `cfgAddr` (combinational) |
| ioAddr | input | 16 | I/O address to decode |
| pmHit | output | 1 | Address falls in the power-management window |
| smbHit | output | 1 | Address falls in the SMBus window |
| ioOffset | output | 6 | Address offset within the hit window |

## Verification
The bench builds the block with its default parameters: 16-bit I/O addresses, a 64-byte power-management window and a 16-byte SMBus window. With these values, every window edge is a concrete address that can be reached directly. The bench probes the first and last byte of each window and the bytes just outside it. It also places the SMBus window inside the power-management window so that both match, then lifts the power-management enable to expose the SMBus window underneath. Random writes then mix byte-enable patterns, unmapped dwords and addresses near both bases.

// File: rtl/pmsmb_pkg.sv
package pmsmb_pkg;

  // Dword indices (byte address >> 2) of the mapped registers
  localparam int unsigned DwPmBase  = 'h10;  // 0x40
  localparam int unsigned DwPmAux   = 'h12;  // 0x48
  localparam int unsigned DwPmCtl   = 'h20;  // 0x80
  localparam int unsigned DwSmbBase = 'h24;  // 0x90
  localparam int unsigned DwSmbCtl  = 'h34;  // 0xD0, control byte in lane 2

  typedef enum logic [2:0] {
    RD_NONE, RD_PMBASE, RD_PMAUX, RD_PMCTL, RD_SMBBASE, RD_SMBCTL
  } rdSel_e;

  typedef struct packed {
    logic [3:0] pmBaseBe;
    logic [3:0] pmAuxBe;
    logic       pmCtlWr;
    logic [3:0] smbBaseBe;
    logic       smbBaseWr;
    logic       smbCtlWr;
    rdSel_e     rdSel;
  } cfgStrobe_t;

endpackage

// File: rtl/pmsmb_cfg_ctrl.sv
module pmsmb_cfg_ctrl
  import pmsmb_pkg::*;
#(
  parameter int CFG_AW = 8
) (
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  output cfgStrobe_t        strobe
);
  localparam int DW_W = CFG_AW - 2;

  logic [DW_W-1:0] dwIdx;
  assign dwIdx = cfgAddr[CFG_AW-1:2];

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    unique case (dwIdx)
      DW_W'(DwPmBase): begin
        strobe.rdSel    = RD_PMBASE;
        strobe.pmBaseBe = cfgWrEn ? cfgByteEn : 4'b0;
      end
      DW_W'(DwPmAux): begin
        strobe.rdSel   = RD_PMAUX;
        strobe.pmAuxBe = cfgWrEn ? cfgByteEn : 4'b0;
      end
      DW_W'(DwPmCtl): begin
        strobe.rdSel   = RD_PMCTL;
        strobe.pmCtlWr = cfgWrEn && cfgByteEn[0];
      end
      DW_W'(DwSmbBase): begin
        strobe.rdSel     = RD_SMBBASE;
        strobe.smbBaseBe = cfgByteEn;
        strobe.smbBaseWr = cfgWrEn && (|cfgByteEn);
      end
      DW_W'(DwSmbCtl): begin
        strobe.rdSel    = RD_SMBCTL;
        strobe.smbCtlWr = cfgWrEn && cfgByteEn[2];
      end
      default: strobe.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/pmsmb_datapath.sv
module pmsmb_datapath
  import pmsmb_pkg::*;
#(
  parameter int IO_AW    = 16,
  parameter int PM_LOG2  = 6,
  parameter int SMB_LOG2 = 4,
  parameter int OFS_W    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       strobe,
  input  logic [31:0]      cfgWrData,
  output logic [31:0]      cfgRdData,
  input  logic [IO_AW-1:0] ioAddr,
  output logic             pmHit,
  output logic             smbHit,
  output logic [OFS_W-1:0] ioOffset
);
  localparam logic [31:0] SMB_KEEP =
    ((32'd1 << IO_AW) - 32'd1) & ~((32'd1 << SMB_LOG2) - 32'd1);

  logic [31:0] pmBaseQ, pmAuxQ, smbBaseQ;
  logic [31:0] pmBaseNext, pmAuxNext, smbMerged;
  logic [7:0]  pmCtlQ;
  logic [3:0]  smbCtlQ;

  // Per-lane merge of write data into the stored dwords
  for (genvar lane = 0; lane < 4; lane++) begin : g_lane
    assign pmBaseNext[8*lane +: 8] =
      strobe.pmBaseBe[lane] ? cfgWrData[8*lane +: 8] : pmBaseQ[8*lane +: 8];
    assign pmAuxNext[8*lane +: 8] =
      strobe.pmAuxBe[lane] ? cfgWrData[8*lane +: 8] : pmAuxQ[8*lane +: 8];
    assign smbMerged[8*lane +: 8] =
      strobe.smbBaseBe[lane] ? cfgWrData[8*lane +: 8] : smbBaseQ[8*lane +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pmBaseQ  <= 32'h0;
      pmAuxQ   <= 32'h1;
      pmCtlQ   <= 8'h0;
      smbBaseQ <= 32'h1;
      smbCtlQ  <= 4'h0;
    end else begin
      pmBaseQ <= pmBaseNext;
      pmAuxQ  <= pmAuxNext;
      if (strobe.pmCtlWr)   pmCtlQ   <= cfgWrData[7:0];
      if (strobe.smbBaseWr) smbBaseQ <= (smbMerged & SMB_KEEP) | 32'h1;
      if (strobe.smbCtlWr)  smbCtlQ  <= cfgWrData[19:16];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_PMBASE:  cfgRdData = pmBaseQ;
      RD_PMAUX:   cfgRdData = pmAuxQ;
      RD_PMCTL:   cfgRdData = {24'h0, pmCtlQ};
      RD_SMBBASE: cfgRdData = smbBaseQ;
      RD_SMBCTL:  cfgRdData = {12'h0, smbCtlQ, 16'h0};
      default:    cfgRdData = 32'h0;
    endcase
  end

  // Window matching; the power-management window wins an overlap
  logic pmMatch, smbMatch;
  assign pmMatch  = pmCtlQ[0] &&
                    (ioAddr[IO_AW-1:PM_LOG2] == pmBaseQ[IO_AW-1:PM_LOG2]);
  assign smbMatch = smbCtlQ[0] &&
                    (ioAddr[IO_AW-1:SMB_LOG2] == smbBaseQ[IO_AW-1:SMB_LOG2]);

  assign pmHit  = pmMatch;
  assign smbHit = smbMatch && !pmMatch;

  always_comb begin
    if (pmMatch)       ioOffset = OFS_W'(ioAddr[PM_LOG2-1:0]);
    else if (smbMatch) ioOffset = OFS_W'(ioAddr[SMB_LOG2-1:0]);
    else               ioOffset = '0;
  end
endmodule

// File: rtl/pmsmb_window_decoder.sv
module pmsmb_window_decoder
  import pmsmb_pkg::*;
#(
  parameter int CFG_AW   = 8,
  parameter int IO_AW    = 16,
  parameter int PM_LOG2  = 6,
  parameter int SMB_LOG2 = 4,
  localparam int OFS_W   = (PM_LOG2 > SMB_LOG2) ? PM_LOG2 : SMB_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic [IO_AW-1:0]  ioAddr,
  output logic              pmHit,
  output logic              smbHit,
  output logic [OFS_W-1:0]  ioOffset
);
  cfgStrobe_t strobe;

  pmsmb_cfg_ctrl #(.CFG_AW(CFG_AW)) u_ctrl (
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgByteEn(cfgByteEn),
    .strobe   (strobe)
  );

  pmsmb_datapath #(
    .IO_AW(IO_AW), .PM_LOG2(PM_LOG2), .SMB_LOG2(SMB_LOG2), .OFS_W(OFS_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .ioAddr   (ioAddr),
    .pmHit    (pmHit),
    .smbHit   (smbHit),
    .ioOffset (ioOffset)
  );
endmodule

// File: rtl/pmsmb_window_chk.sv
module pmsmb_window_chk
  import pmsmb_pkg::*;
#(
  parameter int CFG_AW   = 8,
  parameter int IO_AW    = 16,
  parameter int PM_LOG2  = 6,
  parameter int SMB_LOG2 = 4,
  parameter int OFS_W    = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [CFG_AW-1:0] cfgAddr,
  input logic [3:0]        cfgByteEn,
  input logic [31:0]       cfgWrData,
  input logic [31:0]       cfgRdData,
  input logic [IO_AW-1:0]  ioAddr,
  input logic              pmHit,
  input logic              smbHit,
  input logic [OFS_W-1:0]  ioOffset
);
  localparam int DW_W = CFG_AW - 2;

  // R8
  hits_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pmHit && smbHit));

  // R3
  pm_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmHit |-> ioOffset == OFS_W'(ioAddr[PM_LOG2-1:0]));

  // R7
  smb_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    smbHit |-> ioOffset == OFS_W'(ioAddr[SMB_LOG2-1:0]));

  // R9
  idle_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pmHit && !smbHit) |-> ioOffset == '0);

  // R5
  smb_base_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr[CFG_AW-1:2] == DW_W'(DwSmbBase)) |->
      (cfgRdData[0] && cfgRdData[31:16] == 16'h0));

  // R4
  pm_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr[CFG_AW-1:2] == DW_W'(DwPmCtl) && cfgByteEn[0] &&
     !cfgWrData[0]) |=> !pmHit);

  // R6
  smb_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr[CFG_AW-1:2] == DW_W'(DwSmbCtl) && cfgByteEn[2] &&
     !cfgWrData[16]) |=> !smbHit);
endmodule

bind pmsmb_window_decoder pmsmb_window_chk #(
  .CFG_AW(CFG_AW), .IO_AW(IO_AW), .PM_LOG2(PM_LOG2),
  .SMB_LOG2(SMB_LOG2), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
  .ioAddr(ioAddr), .pmHit(pmHit), .smbHit(smbHit), .ioOffset(ioOffset)
);

// File: tb/tb_pmsmb_window_decoder.sv
module tb_pmsmb_window_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h0;
  logic [3:0]  cfgByteEn = 4'h0;
  logic [31:0] cfgWrData = 32'h0;
  logic [31:0] cfgRdData;
  logic [15:0] ioAddr = 16'h0;
  logic        pmHit, smbHit;
  logic [5:0]  ioOffset;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference state
  logic [31:0] mPmBase, mPmAux, mSmbBase;
  logic [7:0]  mPmCtl;
  logic [3:0]  mSmbCtl;

  always #10 clk = ~clk;

  pmsmb_window_decoder dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .ioAddr(ioAddr), .pmHit(pmHit), .smbHit(smbHit), .ioOffset(ioOffset)
  );

  task automatic modelReset();
    mPmBase = 32'h0; mPmAux = 32'h1; mPmCtl = 8'h0;
    mSmbBase = 32'h1; mSmbCtl = 4'h0;
  endtask

  function automatic logic [31:0] laneMerge(logic [31:0] old, logic [31:0] nw,
                                            logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] modelRead(logic [7:0] a);
    case (a & 8'hFC)
      8'h40:   return mPmBase;
      8'h48:   return mPmAux;
      8'h80:   return {24'h0, mPmCtl};
      8'h90:   return mSmbBase;
      8'hD0:   return {12'h0, mSmbCtl, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWrite(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    case (a & 8'hFC)
      8'h40: mPmBase = laneMerge(mPmBase, d, be);
      8'h48: mPmAux  = laneMerge(mPmAux, d, be);
      8'h80: if (be[0]) mPmCtl = d[7:0];
      8'h90: if (be != 0) mSmbBase = (laneMerge(mSmbBase, d, be) & 32'hFFF0) | 32'h1;
      8'hD0: if (be[2]) mSmbCtl = d[19:16];
      default: ;
    endcase
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare, then advance the model
  task automatic cyc(string tag, logic we, logic [7:0] a, logic [31:0] d,
                     logic [3:0] be, logic [15:0] io);
    logic ePm, eSmb;
    logic [5:0] eOfs;
    @(negedge clk);
    cfgWrEn = we; cfgAddr = a; cfgWrData = d; cfgByteEn = be; ioAddr = io;
    #2;
    ePm  = mPmCtl[0] && ((io & 16'hFFC0) == (mPmBase[15:0] & 16'hFFC0));
    eSmb = mSmbCtl[0] && ((io & 16'hFFF0) == (mSmbBase[15:0] & 16'hFFF0));
    eOfs = ePm ? io[5:0] : (eSmb ? {2'b0, io[3:0]} : 6'h0);
    check(tag, "cfgRdData", cfgRdData, modelRead(a));
    check(tag, "pmHit", {31'h0, pmHit}, {31'h0, ePm});
    check(tag, "smbHit", {31'h0, smbHit}, {31'h0, eSmb && !ePm});
    check(tag, "ioOffset", {26'h0, ioOffset}, {26'h0, eOfs});
    if (we) modelWrite(a, d, be);
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [15:0] io);
    cyc(tag, 1'b0, a, 32'h0, 4'h0, io);
  endtask

  task automatic wr(string tag, logic [7:0] a, logic [31:0] d, logic [3:0] be);
    cyc(tag, 1'b1, a, d, be, 16'h0);
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset values
    rd("R1", 8'h40, 16'h0000); rd("R1", 8'h48, 16'h0000);
    rd("R1", 8'h80, 16'h0000); rd("R1", 8'h90, 16'h0000);
    rd("R1", 8'hD0, 16'h0000);

    // R2: byte-lane writes
    wr("R2", 8'h40, 32'h12345A80, 4'b0011); rd("R2", 8'h40, 16'h5A80);
    wr("R2", 8'h48, 32'hAABBCCDD, 4'b1010); rd("R2", 8'h48, 16'h0);

    // R4: window closed until enabled; only lane 0 stored
    rd("R4", 8'h80, 16'h5ABF);
    wr("R4", 8'h80, 32'hFFFFFFFF, 4'b1111); rd("R4", 8'h80, 16'h5A80);

    // R3: window edges
    rd("R3", 8'h40, 16'h5ABF); rd("R3", 8'h40, 16'h5AC0);
    rd("R3", 8'h40, 16'h5A7F); rd("R3", 8'h40, 16'h5A95);

    // R5: forced bit 0 and alignment mask
    wr("R5", 8'h90, 32'h000000FE, 4'b0001); rd("R5", 8'h90, 16'h0);
    wr("R5", 8'h93, 32'hFFFF300F, 4'b1111); rd("R5", 8'h90, 16'h3000);

    // R6: control byte lane handling
    wr("R6", 8'hD0, 32'hFFFFFFFF, 4'b0100); rd("R6", 8'hD0, 16'h0);
    wr("R6", 8'hD0, 32'h00000000, 4'b1011); rd("R6", 8'hD0, 16'h0);

    // R7: SMBus window edges
    rd("R7", 8'h90, 16'h300C); rd("R7", 8'h90, 16'h3000);
    rd("R7", 8'h90, 16'h300F); rd("R7", 8'h90, 16'h3010);
    rd("R7", 8'h90, 16'h2FFF);

    // R8: overlapping windows
    wr("R8", 8'h90, 32'h00005A90, 4'b0011); rd("R8", 8'h90, 16'h5A95);
    wr("R8", 8'h80, 32'h00000000, 4'b0001); rd("R8", 8'h80, 16'h5A95);
    wr("R8", 8'h80, 32'h00000001, 4'b0001); rd("R8", 8'h80, 16'h5A9F);

    // R9: unmapped dwords, empty byte enables
    wr("R9", 8'h44, 32'hDEADBEEF, 4'b1111); rd("R9", 8'h44, 16'h0);
    wr("R9", 8'h40, 32'hFFFFFFFF, 4'b0000); rd("R9", 8'h42, 16'h5A80);
    rd("R9", 8'h4C, 16'h1234);

    // R6: disabling the SMBus window
    wr("R6", 8'hD2, 32'h000E0000, 4'b0100); rd("R6", 8'hD0, 16'h5A95);

    // Mixed random traffic across all requirements
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [15:0] io;
      int sel = $urandom_range(0, 6);
      case (sel)
        0: a = 8'h40; 1: a = 8'h48; 2: a = 8'h80; 3: a = 8'h90;
        4: a = 8'hD0; default: a = 8'($urandom_range(0, 255));
      endcase
      a = a | 8'($urandom_range(0, 3));
      case ($urandom_range(0, 2))
        0: io = mPmBase[15:0] ^ 16'($urandom_range(0, 127));
        1: io = mSmbBase[15:0] ^ 16'($urandom_range(0, 31));
        default: io = 16'($urandom);
      endcase
      cyc("R2/R9 random", $urandom_range(0, 2) == 0, a, $urandom,
          4'($urandom_range(0, 15)), io);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule